// File: doc/BRIEF.md
# Serial Flash Boot Copier

This block runs once after every reset. It is the SPI master to an external serial flash that takes 24-bit addresses. It copies a firmware image, starting at flash address 0, into an on-chip program RAM, one 256-byte sector per read transaction. The image length is not known in advance. After each sector is read, the block looks for a four-byte trailer in the top four bytes of that sector. The trailer holds two marker bytes and a sector count that must equal the number of sectors read so far. The first sector that carries a valid trailer is the last sector of the image.

When the trailer is found, the block compares two values. The first is an 8-bit modulo-256 sum that it builds over every byte of the image except the four trailer bytes. The second is the checksum stored in the trailer. If they are equal, the block takes the processor out of reset and raises `boot_done`. If they differ, or if no trailer appears within `MAX_SECTORS` sectors, the block raises `boot_err` and keeps the processor in reset until the next reset.

Top module: `flash_boot_copier`

## Requirements
- R1: While `rst_n` is low, `spi_cs_n` is 1, `spi_sck` is 0, `cpu_rst_n` is 0, and `boot_done` and `boot_err` are both 0.
- R2: Each sector is read in its own chip-select-low transaction. The block sends the byte 0x03 and then the address bytes {0x00, sector index, 0x00}, MSB first, and then clocks in data continuously. The interface uses SPI mode 0: SCK is low while idle, MOSI is stable while SCK is high, MISO is sampled on the rising edge, and one SCK half period lasts `CLK_DIV` clocks.
- R3: Every byte read is written to RAM, in flash order, at RAM address sector*256 + offset.
- R4: A sector is the last one when its byte at offset 0xFE is 0xA5, its byte at 0xFF is 0x5A, and its byte at 0xFD equals the 1-based number of sectors read so far. No further sector is read after that.
- R5: A sector whose two marker bytes are correct but whose count byte at 0xFD is wrong is treated as ordinary image data, and reading continues with the next sector.
- R6: The computed checksum is the modulo-256 sum of all bytes from address 0 up to offset 0xFB of the last sector. Bytes at 0xFC..0xFF of earlier sectors are included in this sum. When it equals the byte at offset 0xFC of the last sector, `boot_done` and `cpu_rst_n` go to 1.
- R7: On a checksum mismatch, `boot_err` goes to 1 and `cpu_rst_n` stays 0.
- R8: If `MAX_SECTORS` sectors have been read without a valid trailer, `boot_err` goes to 1, `cpu_rst_n` stays 0, and no further sector is read.
- R9: `boot_done` and `boot_err` are never 1 together. Each stays set until reset. Once either is set, there are no more RAM writes and no more flash transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; copying starts when it is released |
| spi_sck | output | 1 | SPI serial clock (mode 0) |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| ram_we | output | 1 | Program RAM write strobe, one cycle per byte |
| ram_addr | output | RAM_AW | Program RAM byte address |
| ram_wdata | output | 8 | Program RAM write data |
| cpu_rst_n | output | 1 | Processor reset, active low; goes high only after a valid image |
| boot_done | output | 1 | Image copied and checksum matched |
| boot_err | output | 1 | Checksum mismatch or no trailer found |

## Verification
The bound checker tests the following on every cycle:
- SCK is idle low whenever chip select is high.
- MOSI holds still while SCK is high.
- Every RAM write follows a cycle in which the flash was selected.
- The two status flags are exclusive and sticky.
- Once either flag is set, the interface is quiet.
- The processor reset is only released together with `boot_done`.

Only the bench scenarios can show the following, because they depend on image contents:
- The command and address bytes of each transaction.
- The exact stream of RAM writes.
- The sector at which reading stops for a real trailer, for a trailer with the wrong count, and for an image with no trailer.
- The outcome of the checksum comparison.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_XFER,
      ST_EVAL,
      ST_DONE,
      ST_ERR
   } boot_st_t;

   localparam logic [7:0] CMD_READ = 8'h03;
   localparam logic [7:0] MARK_LO  = 8'hA5;
   localparam logic [7:0] MARK_HI  = 8'h5A;
   localparam logic [7:0] OFF_SUM  = 8'hFC;
   localparam logic [7:0] OFF_CNT  = 8'hFD;
   localparam logic [7:0] OFF_MLO  = 8'hFE;
   localparam logic [7:0] OFF_MHI  = 8'hFF;
   localparam int         HDR_LEN  = 4;
   localparam int         SEC_LEN  = 256;
endpackage

// File: rtl/fbc_spi_byte.sv
module fbc_spi_byte #(
   parameter int CLK_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       done,
   output logic [7:0] rx
);
   localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   logic       busy;
   logic       tick;
   logic [2:0] bit_q;
   logic [7:0] tx_q;

   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = busy;
      end else begin : g_div
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         div_q <= '0;
            else if (!busy)                     div_q <= '0;
            else if (div_q == DW'(CLK_DIV - 1)) div_q <= '0;
            else                                div_q <= div_q + 1'b1;
         end
         assign tick = busy && (div_q == DW'(CLK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         sck   <= 1'b0;
         bit_q <= '0;
         tx_q  <= '0;
         rx    <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy  <= 1'b1;
            bit_q <= '0;
            tx_q  <= tx;
            sck   <= 1'b0;
         end else if (tick) begin
            if (!sck) begin
               sck <= 1'b1;
               rx  <= {rx[6:0], miso};
            end else begin
               sck <= 1'b0;
               if (bit_q == 3'd7) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bit_q <= bit_q + 3'd1;
                  tx_q  <= {tx_q[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign mosi = tx_q[7];
endmodule

// File: rtl/fbc_trailer_scan.sv
module fbc_trailer_scan
   import fbc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_vld,
   input  logic [7:0] byte_off,
   input  logic [7:0] byte_data,
   input  logic       commit,
   input  logic [7:0] sec_no,
   output logic       hit,
   output logic       sum_ok
);
   logic [7:0] sum_prev, sum_head;
   logic [7:0] t_sum, t_cnt, t_mlo, t_mhi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_prev <= '0;
         sum_head <= '0;
         t_sum    <= '0;
         t_cnt    <= '0;
         t_mlo    <= '0;
         t_mhi    <= '0;
      end else if (commit) begin
         sum_prev <= sum_prev + sum_head + t_sum + t_cnt + t_mlo + t_mhi;
         sum_head <= '0;
      end else if (byte_vld) begin
         case (byte_off)
            OFF_SUM: t_sum    <= byte_data;
            OFF_CNT: t_cnt    <= byte_data;
            OFF_MLO: t_mlo    <= byte_data;
            OFF_MHI: t_mhi    <= byte_data;
            default: sum_head <= sum_head + byte_data;
         endcase
      end
   end

   assign hit    = (t_mlo == MARK_LO) && (t_mhi == MARK_HI) && (t_cnt == sec_no);
   assign sum_ok = ((sum_prev + sum_head) == t_sum);
endmodule

// File: rtl/flash_boot_copier.sv
module flash_boot_copier
   import fbc_pkg::*;
#(
   parameter int CLK_DIV     = 2,
   parameter int MAX_SECTORS = 128,
   parameter int RAM_AW      = $clog2(MAX_SECTORS * 256)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_cs_n,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   output logic              cpu_rst_n,
   output logic              boot_done,
   output logic              boot_err
);
   localparam int SW      = (MAX_SECTORS > 1) ? $clog2(MAX_SECTORS) : 1;
   localparam int LAST_IX = HDR_LEN + SEC_LEN - 1;

   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end
   if (MAX_SECTORS < 1 || MAX_SECTORS > 255) begin : g_bad_max
      $error("MAX_SECTORS must lie in 1..255");
   end
   if (RAM_AW < $clog2(MAX_SECTORS * 256)) begin : g_bad_aw
      $error("RAM_AW too narrow for MAX_SECTORS");
   end

   boot_st_t      state;
   logic [SW-1:0] sec_q;
   logic [8:0]    idx_q;
   logic          launch_q;
   logic [7:0]    tx_byte;
   logic          eng_done;
   logic [7:0]    eng_rx;
   logic [7:0]    off;
   logic [7:0]    sec_no;
   logic          data_vld;
   logic          commit;
   logic          hit, sum_ok;

   assign off      = idx_q[7:0] - 8'(HDR_LEN);
   assign sec_no   = 8'(sec_q) + 8'd1;
   assign data_vld = (state == ST_XFER) && eng_done && (idx_q >= 9'(HDR_LEN));

   always_comb begin
      case (idx_q[1:0])
         2'd0:    tx_byte = CMD_READ;
         2'd2:    tx_byte = 8'(sec_q);
         default: tx_byte = 8'h00;
      endcase
      if (idx_q >= 9'(HDR_LEN)) tx_byte = 8'h00;
   end

   always_comb begin
      commit = 1'b0;
      if (state == ST_EVAL && !hit && sec_q != SW'(MAX_SECTORS - 1)) commit = 1'b1;
   end

   fbc_spi_byte #(.CLK_DIV(CLK_DIV)) u_eng (
      .clk   (clk),
      .rst_n (rst_n),
      .start (launch_q),
      .tx    (tx_byte),
      .miso  (spi_miso),
      .sck   (spi_sck),
      .mosi  (spi_mosi),
      .done  (eng_done),
      .rx    (eng_rx)
   );

   fbc_trailer_scan u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_vld  (data_vld),
      .byte_off  (off),
      .byte_data (eng_rx),
      .commit    (commit),
      .sec_no    (sec_no),
      .hit       (hit),
      .sum_ok    (sum_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         sec_q     <= '0;
         idx_q     <= '0;
         launch_q  <= 1'b0;
         ram_we    <= 1'b0;
         ram_addr  <= '0;
         ram_wdata <= '0;
      end else begin
         launch_q <= 1'b0;
         ram_we   <= 1'b0;
         case (state)
            ST_IDLE: begin
               state    <= ST_XFER;
               launch_q <= 1'b1;
            end
            ST_XFER: if (eng_done) begin
               if (data_vld) begin
                  ram_we    <= 1'b1;
                  ram_addr  <= RAM_AW'({8'(sec_q), off});
                  ram_wdata <= eng_rx;
               end
               if (idx_q == 9'(LAST_IX)) begin
                  state <= ST_EVAL;
               end else begin
                  idx_q    <= idx_q + 9'd1;
                  launch_q <= 1'b1;
               end
            end
            ST_EVAL: begin
               if (hit)         state <= sum_ok ? ST_DONE : ST_ERR;
               else if (!commit) state <= ST_ERR;
               else begin
                  sec_q    <= sec_q + 1'b1;
                  idx_q    <= '0;
                  launch_q <= 1'b1;
                  state    <= ST_XFER;
               end
            end
            default: state <= state;
         endcase
      end
   end

   assign spi_cs_n  = (state != ST_XFER);
   assign boot_done = (state == ST_DONE);
   assign boot_err  = (state == ST_ERR);
   assign cpu_rst_n = (state == ST_DONE);
endmodule

// File: rtl/fbc_checker.sv
module fbc_checker #(
   parameter int RAM_AW = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              spi_sck,
   input logic              spi_mosi,
   input logic              spi_cs_n,
   input logic              ram_we,
   input logic [RAM_AW-1:0] ram_addr,
   input logic              cpu_rst_n,
   input logic              boot_done,
   input logic              boot_err
);
   p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);
   p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && spi_sck) |-> $stable(spi_mosi));
   p_write_after_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> $past(!spi_cs_n));
   p_addr_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> !$isunknown(ram_addr));
   p_release_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rst_n) |-> boot_done);
   p_hold_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      boot_err |-> !cpu_rst_n);
   p_status_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(boot_done && boot_err));
   p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |=> boot_done);
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      boot_err |=> boot_err);
   p_quiet_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_done || boot_err) |-> (spi_cs_n && !ram_we));
endmodule

bind flash_boot_copier fbc_checker #(.RAM_AW(RAM_AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .spi_sck   (spi_sck),
   .spi_mosi  (spi_mosi),
   .spi_cs_n  (spi_cs_n),
   .ram_we    (ram_we),
   .ram_addr  (ram_addr),
   .cpu_rst_n (cpu_rst_n),
   .boot_done (boot_done),
   .boot_err  (boot_err)
);

// File: tb/flash_boot_copier_test.sv
`timescale 1ns/1ps
module flash_boot_copier_test;
   localparam int CLK_DIV = 2;
   localparam int MAXS    = 4;
   localparam int AW      = 10;
   localparam int FSZ     = 2048;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck, mosi, miso, cs_n, we, cpu_rst_n, done, err;
   logic [AW-1:0] waddr;
   logic [7:0] wdata;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   flash_boot_copier #(.CLK_DIV(CLK_DIV), .MAX_SECTORS(MAXS), .RAM_AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso),
      .spi_cs_n(cs_n), .ram_we(we), .ram_addr(waddr), .ram_wdata(wdata),
      .cpu_rst_n(cpu_rst_n), .boot_done(done), .boot_err(err));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // flash model
   logic [7:0] flash [0:FSZ-1];
   int txn_count = 0;
   int txn_base = 0;
   int bitcnt = 0;
   logic [31:0] shin = '0;

   always @(negedge cs_n) begin
      bitcnt = 0;
      txn_count++;
   end

   always @(posedge sck) if (!cs_n) begin
      if (bitcnt < 32) shin = {shin[30:0], mosi};
      bitcnt++;
      if (bitcnt == 32) begin
         check(shin[31:24] == 8'h03, "R2 read command", int'(shin[31:24]), 3);
         check(shin[23:0] == 24'((txn_count - txn_base - 1) * 256), "R2 sector address",
               int'(shin[23:0]), (txn_count - txn_base - 1) * 256);
      end
   end

   always @(negedge sck) if (!cs_n && bitcnt >= 32) begin
      int k;
      k = bitcnt - 32;
      miso = flash[(int'(shin[23:0]) + k / 8) % FSZ][7 - (k % 8)];
   end

   // scoreboard
   int exp_addr_q[$];
   int exp_data_q[$];

   always @(negedge clk) if (rst_n && we) begin
      if (exp_addr_q.size() == 0) begin
         check(1'b0, "R9 unexpected RAM write", int'(waddr), -1);
      end else begin
         int ea, ed;
         ea = exp_addr_q.pop_front();
         ed = exp_data_q.pop_front();
         check(int'(waddr) == ea && int'(wdata) == ed, "R3 RAM write",
               (int'(waddr) << 8) | int'(wdata), (ea << 8) | ed);
      end
   end

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 11) ^ (i >> 5));
   endfunction

   // build image: fw bytes, trailer in sector s (0 = none), push expected writes for nrd sectors
   task automatic build(input int fw, input int s, input int sum_bias, input int nrd);
      logic [7:0] cs;
      for (int i = 0; i < FSZ; i++) flash[i] = (i < fw) ? pat(i) : 8'h00;
      if (s == 0) for (int j = 0; j < MAXS; j++) flash[j * 256 + 254] = 8'h00;
      if (s > 0) begin
         cs = '0;
         for (int i = 0; i < (s - 1) * 256 + 252; i++) cs = cs + flash[i];
         flash[(s - 1) * 256 + 252] = cs + 8'(sum_bias);
         flash[(s - 1) * 256 + 253] = 8'(s);
         flash[(s - 1) * 256 + 254] = 8'hA5;
         flash[(s - 1) * 256 + 255] = 8'h5A;
      end
      for (int i = 0; i < nrd * 256; i++) begin
         exp_addr_q.push_back(i);
         exp_data_q.push_back(int'(flash[i]));
      end
   endtask

   task automatic run(input string name, input bit exp_ok, input int exp_txn);
      int lim;
      int t_end;
      txn_base = txn_count;
      @(negedge clk) rst_n = 1'b1;
      lim = 0;
      while (!done && !err && lim < 60000) begin
         @(negedge clk);
         lim++;
      end
      check(done == exp_ok && err == !exp_ok, exp_ok ? "R6 boot_done" : "R7/R8 boot_err",
            {30'd0, done, err}, exp_ok ? 2 : 1);
      check(cpu_rst_n == exp_ok, exp_ok ? "R6 cpu released" : "R7 cpu held",
            int'(cpu_rst_n), int'(exp_ok));
      check(txn_count - txn_base == exp_txn, exp_ok ? "R4 sectors read" : "R8 sectors read",
            txn_count - txn_base, exp_txn);
      check(exp_addr_q.size() == 0, "R3 all writes seen", exp_addr_q.size(), 0);
      t_end = txn_count;
      repeat (1500) @(negedge clk);
      check(done == exp_ok && err == !exp_ok, "R9 status sticky", {30'd0, done, err},
            exp_ok ? 2 : 1);
      check(txn_count == t_end && cs_n, "R9 no further reads", txn_count - t_end, 0);
      $display("scenario %s complete", name);
      rst_n = 1'b0;
      exp_addr_q.delete();
      exp_data_q.delete();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check(cs_n == 1'b1, "R1 cs idle", int'(cs_n), 1);
      check(sck == 1'b0, "R1 sck idle", int'(sck), 0);
      check(cpu_rst_n == 1'b0, "R1 cpu held", int'(cpu_rst_n), 0);
      check(!done && !err, "R1 status clear", {30'd0, done, err}, 0);

      build(618, 3, 0, 3);  run("three sectors", 1'b1, 3);     // R4 R6
      build(252, 1, 0, 1);  run("exact fit", 1'b1, 1);         // R4 boundary
      build(300, 2, 0, 2);                                     // R5 fake trailer in sector 1
      flash[253] = 8'h07; flash[254] = 8'hA5; flash[255] = 8'h5A;
      exp_addr_q.delete(); exp_data_q.delete();
      build_fixup();
      run("wrong count marker", 1'b1, 2);
      build(400, 2, 1, 2);  run("bad checksum", 1'b0, 2);      // R7
      build(1100, 0, 0, MAXS); run("no trailer", 1'b0, MAXS);  // R8

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // recompute trailer checksum and expected writes after the fake-marker edit (R5)
   task automatic build_fixup();
      logic [7:0] cs;
      cs = '0;
      for (int i = 0; i < 256 + 252; i++) cs = cs + flash[i];
      flash[256 + 252] = cs;
      for (int i = 0; i < 512; i++) begin
         exp_addr_q.push_back(i);
         exp_data_q.push_back(int'(flash[i]));
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule